// File: doc/BRIEF.md
# Burst Line-Fill Memory Controller

This controller sits between a processor cache and a page-mode DRAM. It serves two kinds of read request. A single-word read gets one full-latency access. A cache-line fill returns the four 32-bit words of an aligned line. The caller presents a word address and a line flag. The controller answers with one valid pulse per returned word and marks the final word with a last flag. While a request is in progress the controller accepts no other.

A line fill can run in two ways. When the controller's burst enable and the memory's burst capability are both set, the first word comes after the full access latency. The remaining three words then follow on consecutive clocks. During those clocks the row stays open and only the column steps, with no precharge in between. When either setting is off, the line is fetched as four independent full-latency accesses. Each access starts with a precharge clock. The data is the same in both cases and only the timing differs. In both cases the words come back in wrap-around order: the fill starts at the requested word and increments modulo four within the line.

The memory address is the longword address split in two. The upper `ROW_W` bits form the row. The lower `COL_W` bits form the column. The two least significant column bits select the word within the line.

Top module: `line_fill_ctrl`

## Requirements
- R1: During and after reset, with no request pending, `req_ready` is 1, `rsp_valid` is 0, and both `mem_ras_n` and `mem_cas_n` are 1.
- R2: A request with `req_line`=0 produces exactly one `rsp_valid` pulse, 5 clock edges after the accepting edge. This holds whatever the burst configuration is.
- R3: A request with `req_line`=1, while both `cfg_burst_en` and `cfg_mem_burst` are 1, produces four `rsp_valid` pulses at edges 5, 6, 7 and 8 after acceptance.
- R4: A request with `req_line`=1, while either configuration input is 0, produces four `rsp_valid` pulses at edges 5, 10, 15 and 20 after acceptance.
- R5: Beat n of a line fill (n = 0..3) addresses longword `{req_lwa[LWA_W-1:2], (req_lwa[1:0]+n) mod 4}` on `{mem_row, mem_col}`. Row and upper column bits stay fixed for the whole line.
- R6: `rsp_last` is 1 on the final beat of every request and 0 on every other beat.
- R7: `req_ready` is 0 from the accepting edge up to the edge of the final beat, and is 1 in the clock after it. `req_valid` asserted while busy is ignored and produces no extra beats.
- R8: Between burst beats `mem_ras_n` stays 0, so there is no precharge. In the fallback mode `mem_ras_n` returns to 1 for one clock before each following access.
- R9: On every beat `rsp_data` equals the memory word at the longword addressed on that beat, sampled while `mem_cas_n` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_burst_en | input | 1 | Controller burst fills allowed |
| cfg_mem_burst | input | 1 | Memory supports column-stepping burst |
| req_valid | input | 1 | Request present |
| req_lwa | input | ROW_W+COL_W | Requested longword address |
| req_line | input | 1 | 1 = four-word line fill, 0 = single word |
| req_ready | output | 1 | Controller idle, request accepted on this edge |
| rsp_valid | output | 1 | One returned word on this clock |
| rsp_last | output | 1 | Final word of the request |
| rsp_data | output | DW | Returned word |
| mem_row | output | ROW_W | Memory row address |
| mem_col | output | COL_W | Memory column address |
| mem_ras_n | output | 1 | Row strobe, active low |
| mem_cas_n | output | 1 | Column strobe, active low |
| mem_rdata | input | DW | Memory read data |

## Verification
The bench builds the controller with `ROW_W`=4 and `COL_W`=3. This makes the longword space 128 entries with one upper column bit. At that size, every starting word within a line can be swept under each of the five request and configuration combinations, and on rows at both ends of the address range. Expected beat times of 5, 8 and 20 clocks, wrap order and data all come from arithmetic on the requested address. A busy-time request with a different address checks that nothing is accepted early.

// File: rtl/lfc_pkg.sv
package lfc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ACCESS = 2'd1,
    ST_BURST  = 2'd2
  } lfc_state_e;
endpackage

// File: rtl/lfc_rst_sync.sv
module lfc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/lfc_seq.sv
module lfc_seq
  import lfc_pkg::*;
#(
  parameter int ACC_LAT    = 5,
  parameter int LINE_WORDS = 4,
  localparam int CW = $clog2(ACC_LAT),
  localparam int BW = $clog2(LINE_WORDS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_line,
  input  logic          burst_ok,
  output logic          ready,
  output logic          start,
  output logic [BW-1:0] beat,
  output logic          ack,
  output logic          last,
  output logic          ras_n,
  output logic          cas_n
);
  localparam logic [CW-1:0] LAST_CNT  = CW'(ACC_LAT - 1);
  localparam logic [CW-1:0] CAS_FROM  = CW'(ACC_LAT - 2);
  localparam logic [BW-1:0] LAST_BEAT = BW'(LINE_WORDS - 1);

  lfc_state_e    state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [BW-1:0] beat_q, beat_d;
  logic          line_q, line_d;
  logic          burst_q, burst_d;

  assign ready = (state_q == ST_IDLE);
  assign start = req_valid && ready;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    beat_d  = beat_q;
    line_d  = line_q;
    burst_d = burst_q;
    case (state_q)
      ST_IDLE: begin
        if (start) begin
          state_d = ST_ACCESS;
          cnt_d   = '0;
          beat_d  = '0;
          line_d  = req_line;
          burst_d = req_line && burst_ok;
        end
      end
      ST_ACCESS: begin
        if (cnt_q == LAST_CNT) begin
          if (!line_q || beat_q == LAST_BEAT) begin
            state_d = ST_IDLE;
          end else if (burst_q) begin
            state_d = ST_BURST;
            beat_d  = beat_q + BW'(1);
          end else begin
            cnt_d  = '0;
            beat_d = beat_q + BW'(1);
          end
        end else begin
          cnt_d = cnt_q + CW'(1);
        end
      end
      ST_BURST: begin
        if (beat_q == LAST_BEAT) state_d = ST_IDLE;
        else                     beat_d  = beat_q + BW'(1);
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      beat_q  <= '0;
      line_q  <= 1'b0;
      burst_q <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      beat_q  <= beat_d;
      line_q  <= line_d;
      burst_q <= burst_d;
    end
  end

  assign beat  = beat_q;
  assign ack   = ((state_q == ST_ACCESS) && (cnt_q == LAST_CNT)) || (state_q == ST_BURST);
  assign last  = ack && (!line_q || beat_q == LAST_BEAT);
  assign ras_n = !(((state_q == ST_ACCESS) && (cnt_q != '0)) || (state_q == ST_BURST));
  assign cas_n = !(((state_q == ST_ACCESS) && (cnt_q >= CAS_FROM)) || (state_q == ST_BURST));

  // R1: idle controller is quiet on both sides
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> (!ack && ras_n && cas_n));
  // R9: a word is only returned under an active column strobe
  p_data_under_cas_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> !cas_n);
  // R8: burst beats keep the row open, no precharge clock
  p_burst_row_open_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_BURST) |-> (!ras_n && $past(!ras_n)));
  // R7: busy until the final beat, idle right after it
  p_busy_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!ready && !last) |=> !ready);
  p_last_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    last |=> ready);
endmodule

// File: rtl/lfc_addr.sv
module lfc_addr #(
  parameter int ROW_W = 8,
  parameter int COL_W = 6,
  parameter int BW    = 2,
  localparam int LWA_W = ROW_W + COL_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [LWA_W-1:0] start_lwa,
  input  logic [BW-1:0]    beat,
  output logic [ROW_W-1:0] row,
  output logic [COL_W-1:0] col
);
  logic [ROW_W-1:0] row_q;
  logic [BW-1:0]    word_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_q  <= '0;
      word_q <= '0;
    end else if (start) begin
      row_q  <= start_lwa[LWA_W-1:COL_W];
      word_q <= start_lwa[BW-1:0];
    end
  end

  if (COL_W > BW) begin : g_upper_col
    logic [COL_W-BW-1:0] hi_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     hi_q <= '0;
      else if (start) hi_q <= start_lwa[COL_W-1:BW];
    end
    assign col = {hi_q, BW'(word_q + beat)};
  end else begin : g_word_only
    assign col = BW'(word_q + beat);
  end

  assign row = row_q;

  // R5: row is frozen between request starts
  p_row_fixed_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> $stable(row));
  // R5: each new beat moves the in-line word by one, modulo the line
  p_word_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(start) && (beat != $past(beat))) |->
      (col[BW-1:0] == BW'($past(col[BW-1:0]) + BW'(1))));
endmodule

// File: rtl/line_fill_ctrl.sv
module line_fill_ctrl #(
  parameter int ROW_W      = 8,
  parameter int COL_W      = 6,
  parameter int DW         = 32,
  parameter int ACC_LAT    = 5,
  parameter int LINE_WORDS = 4,
  localparam int LWA_W = ROW_W + COL_W,
  localparam int BW    = $clog2(LINE_WORDS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_burst_en,
  input  logic             cfg_mem_burst,
  input  logic             req_valid,
  input  logic [LWA_W-1:0] req_lwa,
  input  logic             req_line,
  output logic             req_ready,
  output logic             rsp_valid,
  output logic             rsp_last,
  output logic [DW-1:0]    rsp_data,
  output logic [ROW_W-1:0] mem_row,
  output logic [COL_W-1:0] mem_col,
  output logic             mem_ras_n,
  output logic             mem_cas_n,
  input  logic [DW-1:0]    mem_rdata
);
  logic          rst_int_n;
  logic          start;
  logic [BW-1:0] beat;
  logic          burst_ok;

  assign burst_ok = cfg_burst_en && cfg_mem_burst;

  lfc_rst_sync i_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  lfc_seq #(
    .ACC_LAT    (ACC_LAT),
    .LINE_WORDS (LINE_WORDS)
  ) i_seq (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .req_valid (req_valid),
    .req_line  (req_line),
    .burst_ok  (burst_ok),
    .ready     (req_ready),
    .start     (start),
    .beat      (beat),
    .ack       (rsp_valid),
    .last      (rsp_last),
    .ras_n     (mem_ras_n),
    .cas_n     (mem_cas_n)
  );

  lfc_addr #(
    .ROW_W (ROW_W),
    .COL_W (COL_W),
    .BW    (BW)
  ) i_addr (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .start     (start),
    .start_lwa (req_lwa),
    .beat      (beat),
    .row       (mem_row),
    .col       (mem_col)
  );

  assign rsp_data = mem_rdata;

  // R6: a single-word request always ends on its only beat
  p_single_last_r6: assert property (@(posedge clk) disable iff (!rst_int_n)
    (start && !req_line) |=> (!rsp_valid || rsp_last));
endmodule

// File: tb/test_line_fill_ctrl.sv
module test_line_fill_ctrl;
  localparam int ROW_W = 4;
  localparam int COL_W = 3;
  localparam int DW = 32;
  localparam int LWA_W = ROW_W + COL_W;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, cfg_burst_en, cfg_mem_burst, req_valid, req_line;
  logic [LWA_W-1:0] req_lwa;
  logic req_ready, rsp_valid, rsp_last, mem_ras_n, mem_cas_n;
  logic [DW-1:0] rsp_data, mem_rdata;
  logic [ROW_W-1:0] mem_row;
  logic [COL_W-1:0] mem_col;

  int errors = 0;
  int checks = 0;

  function automatic logic [DW-1:0] model(input logic [LWA_W-1:0] a);
    return (32'(a) * 32'h0001_0003) ^ 32'h5A3C_0F00;
  endfunction

  assign mem_rdata = mem_cas_n ? '0 : model({mem_row, mem_col});

  line_fill_ctrl #(.ROW_W(ROW_W), .COL_W(COL_W), .DW(DW), .ACC_LAT(5), .LINE_WORDS(4))
  i_line_fill_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_burst_en(cfg_burst_en), .cfg_mem_burst(cfg_mem_burst),
    .req_valid(req_valid), .req_lwa(req_lwa), .req_line(req_line), .req_ready(req_ready),
    .rsp_valid(rsp_valid), .rsp_last(rsp_last), .rsp_data(rsp_data),
    .mem_row(mem_row), .mem_col(mem_col), .mem_ras_n(mem_ras_n), .mem_cas_n(mem_cas_n),
    .mem_rdata(mem_rdata)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // one request; mode: single (R2), burst (R3) or fallback (R4)
  task automatic run_txn(input logic [LWA_W-1:0] lwa, input bit line,
                         input bit ben, input bit mben, input bit poke);
    bit burst = line && ben && mben;
    int nb = line ? 4 : 1;
    int last_t = !line ? 5 : (burst ? 8 : 20);
    int bi = 0;
    string mreq = !line ? "R2" : (burst ? "R3" : "R4");
    @(negedge clk);
    chk(req_ready == 1'b1, "R7", "ready before request", 32'(req_ready), 1);
    cfg_burst_en = ben; cfg_mem_burst = mben;
    req_valid = 1'b1; req_lwa = lwa; req_line = line;
    @(posedge clk);
    for (int k = 1; k <= last_t + 1; k++) begin
      @(negedge clk);
      if (k == 1) begin
        if (poke) begin
          req_lwa = ~lwa; req_line = !line;
        end else req_valid = 1'b0;
      end
      if (k <= last_t) begin
        if (rsp_valid) begin
          logic [LWA_W-1:0] e;
          int t;
          e = {lwa[LWA_W-1:2], 2'(lwa[1:0] + 2'(bi))};
          t = !line ? 5 : (burst ? 5 + bi : 5 * (bi + 1));
          chk(bi < nb && k == t, mreq, "beat time", 32'(k), 32'(t));
          chk({mem_row, mem_col} == e, "R5", "beat address", 32'({mem_row, mem_col}), 32'(e));
          chk(rsp_data == model(e), "R9", "beat data", rsp_data, model(e));
          chk(rsp_last == (bi == nb - 1), "R6", "last flag", 32'(rsp_last), 32'(bi == nb - 1));
          if (burst && bi > 0)
            chk(mem_ras_n == 1'b0, "R8", "row open in burst", 32'(mem_ras_n), 0);
          bi++;
        end
        if (line && !burst && (k == 6 || k == 11 || k == 16))
          chk(mem_ras_n == 1'b1, "R8", "precharge between accesses", 32'(mem_ras_n), 1);
        if (k < last_t && k != 5 && !(line && (burst ? k > 5 : (k % 5 == 0))))
          chk(req_ready == 1'b0, "R7", "busy while serving", 32'(req_ready), 0);
      end else begin
        chk(bi == nb, mreq, "beat count", 32'(bi), 32'(nb));
        chk(req_ready == 1'b1 && rsp_valid == 1'b0, "R7", "idle after last beat",
            32'({req_ready, rsp_valid}), 32'b10);
        req_valid = 1'b0;
      end
    end
    if (poke) begin
      for (int j = 0; j < 3; j++) begin
        @(negedge clk);
        chk(rsp_valid == 1'b0, "R7", "busy-time request ignored", 32'(rsp_valid), 0);
      end
    end
  endtask

  initial begin
    rst_n = 1'b0; cfg_burst_en = 1'b0; cfg_mem_burst = 1'b0;
    req_valid = 1'b0; req_lwa = '0; req_line = 1'b0;
    repeat (3) @(negedge clk);
    chk(req_ready && !rsp_valid && mem_ras_n && mem_cas_n, "R1", "reset outputs",
        32'({req_ready, rsp_valid, mem_ras_n, mem_cas_n}), 32'b1011);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(req_ready && !rsp_valid && mem_ras_n && mem_cas_n, "R1", "idle after reset",
        32'({req_ready, rsp_valid, mem_ras_n, mem_cas_n}), 32'b1011);
    for (int r = 0; r < 3; r++) begin
      for (int w = 0; w < 4; w++) begin
        logic [LWA_W-1:0] a;
        a = {4'(r == 0 ? 0 : (r == 1 ? 9 : 15)), 1'(r), 2'(w)};
        run_txn(a, 1'b0, 1'b1, 1'b1, 1'b0); // R2 with burst enabled
        run_txn(a, 1'b0, 1'b0, 1'b0, 1'b0); // R2
        run_txn(a, 1'b1, 1'b1, 1'b1, w == 2); // R3
        run_txn(a, 1'b1, 1'b0, 1'b1, 1'b0); // R4 controller off
        run_txn(a, 1'b1, 1'b1, 1'b0, w == 1); // R4 memory off
      end
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule